// File: doc/BRIEF.md
# Phase Accumulator for Direct Digital Synthesis

This block is the phase register of a direct digital frequency synthesizer. On every rising clock edge it adds a frequency tuning word to an unsigned phase word of `PHASE_W` bits, so that the phase completes one full turn every 2^PHASE_W / N clocks. The synthesized frequency is therefore N·Fclk / 2^PHASE_W. The phase word feeds a phase-to-amplitude stage that sits outside this block.

A one-bit policy input chooses what happens when an addition runs past the top of the range. In modulo policy the carry is dropped and the low bits are kept, which preserves the fractional phase and gives an exact long-run frequency. In clear policy the phase restarts at zero whenever the new sum is smaller than the old phase. Both policies raise a single-cycle wrap pulse on every such overflow.

Top module: `phase_accum`

## Requirements
- R1: While `rst_n` is low at a rising edge, `phase` becomes 0 and `wrap_pulse` becomes 0 at that edge (synchronous, active low).
- R2: At each rising edge out of reset, `phase` takes the value of the addition of `tune_word` to the previous `phase`, visible from that edge on (one register of latency).
- R3: With `clear_on_wrap` = 0, the new phase is (old phase + `tune_word`) modulo 2^PHASE_W.
- R4: With `clear_on_wrap` = 1, when the PHASE_W-bit sum is smaller than the old phase (overflow), the new phase is 0; otherwise it is the sum.
- R5: `wrap_pulse` is 1 for exactly the cycle following an edge whose addition overflowed, under either policy, and 0 after every other edge.
- R6: A `tune_word` of 0 holds `phase` constant and never raises `wrap_pulse`.
- R7: Changes of `tune_word` or `clear_on_wrap` take effect at the first rising edge that samples them, with no further delay.
- R8: In modulo policy, starting from phase 0, exactly N wrap pulses occur over 2^PHASE_W consecutive edges with tuning word N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tune_word | input | PHASE_W | Frequency tuning word N, sampled every edge |
| clear_on_wrap | input | 1 | Wrap policy: 0 = modulo, 1 = clear to zero on overflow |
| phase | output | PHASE_W | Registered phase word |
| wrap_pulse | output | 1 | One-cycle overflow indication |

## Verification
Both `phase` and `wrap_pulse` are due one edge after the inputs that produced them are sampled: the bench changes inputs at a falling edge, waits for the next rising edge, advances its own arithmetic model by one addition, and compares at the following falling edge. A 6-bit instance is swept over every tuning word under both policies for more than a full phase turn, which covers each overflow case, the zero word and the largest word. Mid-run changes of word and policy are compared the same way, exactly one edge later.

// File: rtl/pa_pkg.sv
// Shared definitions for the phase accumulator.
// Assumes: nothing beyond standard SystemVerilog packages.
package pa_pkg;
    // Overflow handling policy selected by the clear_on_wrap input.
    typedef enum logic {
        WRAP_MODULO = 1'b0,
        WRAP_CLEAR  = 1'b1
    } wrap_policy_e;
endpackage

// File: rtl/pa_adder.sv
// Adds the tuning word to the current phase and flags overflow.
// Assumes: unsigned operands; overflow is found by comparing the
// truncated sum with the old phase, not by a carry output.
module pa_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_phase,
    input  logic [W-1:0] step,
    output logic [W-1:0] sum,
    output logic         ovf
);
    // Truncated addition and the sum-below-old overflow test.
    always_comb begin
        sum = cur_phase + step;
        ovf = (sum < cur_phase);
    end
endmodule

// File: rtl/pa_next_sel.sv
// Chooses the next phase word according to the wrap policy.
// Assumes: ovf is valid for the sum presented in the same cycle.
module pa_next_sel #(
    parameter int W = 32
) (
    input  pa_pkg::wrap_policy_e policy,
    input  logic [W-1:0]         sum,
    input  logic                 ovf,
    output logic [W-1:0]         nxt
);
    import pa_pkg::*;
    // Clear policy forces zero on overflow; modulo keeps the low bits.
    always_comb begin
        if (policy == WRAP_CLEAR && ovf) nxt = '0;
        else                             nxt = sum;
    end
endmodule

// File: rtl/pa_state_reg.sv
// Holds the phase word and the wrap flag.
// Assumes: synchronous active-low reset sampled on the rising edge.
module pa_state_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] nxt,
    input  logic         ovf,
    output logic [W-1:0] q,
    output logic         wrap_q
);
    // Register the next phase and the overflow of this addition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            wrap_q <= 1'b0;
        end else begin
            q      <= nxt;
            wrap_q <= ovf;
        end
    end
endmodule

// File: rtl/phase_accum.sv
// Top level of the DDS phase accumulator with selectable wrap policy.
// Assumes: clear_on_wrap is static or driven synchronously to clk.
module phase_accum #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tune_word,
    input  logic               clear_on_wrap,
    output logic [PHASE_W-1:0] phase,
    output logic               wrap_pulse
);
    import pa_pkg::*;

    logic [PHASE_W-1:0] sum_w;
    logic [PHASE_W-1:0] nxt_w;
    logic               ovf_w;
    wrap_policy_e       policy_w;

    // Map the policy pin onto the enumerated type.
    always_comb policy_w = wrap_policy_e'(clear_on_wrap);

    pa_adder #(.W(PHASE_W)) u_add (
        .cur_phase (phase),
        .step      (tune_word),
        .sum       (sum_w),
        .ovf       (ovf_w)
    );

    pa_next_sel #(.W(PHASE_W)) u_sel (
        .policy (policy_w),
        .sum    (sum_w),
        .ovf    (ovf_w),
        .nxt    (nxt_w)
    );

    pa_state_reg #(.W(PHASE_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt    (nxt_w),
        .ovf    (ovf_w),
        .q      (phase),
        .wrap_q (wrap_pulse)
    );
endmodule

// File: rtl/pa_checker.sv
// Temporal checks on the accumulator ports, bound into phase_accum.
// Assumes: the checks start only after a first reset edge.
module pa_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] tune_word,
    input logic         clear_on_wrap,
    input logic [W-1:0] phase,
    input logic         wrap_pulse
);
    logic         armed;
    logic [W:0]   wide_sum;
    logic         carry;

    // Arm once a reset edge has given the phase a defined value.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b1;
    end

    // Widened addition from the ports; the extra bit marks overflow.
    always_comb begin
        wide_sum = {1'b0, phase} + {1'b0, tune_word};
        carry    = wide_sum[W];
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (phase == '0 && !wrap_pulse));

    assert_modulo_step_R3: assert property (@(posedge clk) disable iff (!rst_n || armed !== 1'b1)
        !clear_on_wrap |=> phase == $past(wide_sum[W-1:0]));

    assert_clear_on_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n || armed !== 1'b1)
        (clear_on_wrap && carry) |=> phase == '0);

    assert_wrap_on_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n || armed !== 1'b1)
        carry |=> wrap_pulse);

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n || armed !== 1'b1)
        !carry |=> !wrap_pulse);

    assert_hold_zero_word_R6: assert property (@(posedge clk) disable iff (!rst_n || armed !== 1'b1)
        (tune_word == '0) |=> (phase == $past(phase) && !wrap_pulse));
endmodule

bind phase_accum pa_checker #(.W(PHASE_W)) u_pa_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tune_word     (tune_word),
    .clear_on_wrap (clear_on_wrap),
    .phase         (phase),
    .wrap_pulse    (wrap_pulse)
);

// File: tb/tb_phase_accum.sv
module tb_phase_accum;
    localparam int  W       = 6;
    localparam int  SPAN    = 1 << W;
    localparam time CLK_PER = 10ns;
    localparam int  WDOG    = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] tune_word = '0;
    logic         clear_on_wrap = 1'b0;
    logic [W-1:0] phase;
    logic         wrap_pulse;

    int vectors = 0;
    int misses  = 0;
    int m_phase = 0;
    int m_wrap  = 0;
    bit done    = 1'b0;

    phase_accum #(.PHASE_W(W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tune_word     (tune_word),
        .clear_on_wrap (clear_on_wrap),
        .phase         (phase),
        .wrap_pulse    (wrap_pulse)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Compare both outputs with the model; tag names the requirement.
    task automatic compare(input string tag);
        vectors++;
        if (phase !== W'(m_phase) || wrap_pulse !== m_wrap[0]) begin
            misses++;
            $display("FAIL %s: phase=%0d wrap=%0b expected phase=%0d wrap=%0d",
                     tag, phase, wrap_pulse, m_phase, m_wrap);
        end
    endtask

    // Apply inputs at a falling edge, advance one rising edge, check.
    task automatic step(input bit rst, input int n, input bit clr, input string tag);
        int s;
        rst_n         = !rst;
        tune_word     = W'(n);
        clear_on_wrap = clr;
        @(posedge clk);
        if (rst) begin
            m_phase = 0; m_wrap = 0;
        end else begin
            s       = m_phase + n;
            m_wrap  = (s >= SPAN) ? 1 : 0;
            m_phase = (clr && s >= SPAN) ? 0 : s % SPAN;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        int wraps;
        @(negedge clk);
        step(1, 37, 1, "R1 reset");
        step(1, 5, 0, "R1 reset held");

        // R3/R8: every tuning word, modulo policy, one full turn
        for (int n = 0; n < SPAN; n++) begin
            step(1, 0, 0, "R1 reset between runs");
            wraps = 0;
            for (int c = 0; c < SPAN; c++) begin
                step(0, n, 0, (n == 0) ? "R6 zero word" : "R2 R3 modulo step");
                wraps += int'(wrap_pulse);
            end
            vectors++;
            if (wraps != n) begin
                misses++;
                $display("FAIL R8: wraps=%0d expected %0d", wraps, n);
            end
        end

        // R4/R5: every tuning word, clear policy
        for (int n = 0; n < SPAN; n++) begin
            step(1, 0, 1, "R1 reset between runs");
            for (int c = 0; c < SPAN + 3; c++)
                step(0, n, 1, "R4 R5 clear step");
        end

        // R7: word and policy changes apply at the next edge
        step(1, 0, 0, "R1 reset");
        step(0, 20, 0, "R7 first word");
        step(0, 50, 0, "R7 word change");
        step(0, 60, 1, "R7 policy to clear");
        step(0, 3, 0, "R7 policy back");
        step(0, 0, 0, "R6 hold");
        step(0, 0, 1, "R6 hold clear");
        step(0, SPAN - 1, 0, "R5 max word");
        step(0, SPAN - 1, 1, "R4 max word clear");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: cycles=%0d expected completion", WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule